// File: doc/BRIEF.md
# Core memory command sequencer

This block is a clocked controller placed between a bus master and a core memory array. The master lowers an active-low strobe together with a read/write select, a byte select and the lowest address bit. After a short settle interval the controller latches that command. It then runs a timed sequence: for reads, a read-initiate pulse followed by data-lane enabling once the memory reports data; for writes, a write-timing interval followed by a zone write-enable pulse. It ends every transfer with an active-low completion pulse.

Each interval is produced by a down-counter clocked from a fixed system clock, so every pulse width is an exact number of cycles. A byte write goes to a single zone of the memory chosen by the address bit; a full word goes to both zones. After completion the controller holds until the master removes its strobe. A new transfer starts only while the memory signals that it is available. A strobe that arrives while the memory is busy waits for the memory and is never lost.

Top module: `core_cmd_seq`

## Requirements
- R1: After the strobe is seen low in idle with the memory available, a settle interval of SETTLE_CYC cycles (default 4) runs; at its end the read/write flag, byte flag and address bit 0 are latched, and later changes of those inputs have no effect on the rest of the transfer.
- R2: For a read (wr_n high), rd_init is high for exactly RDINIT_CYC cycles (default 25), starting in the first cycle after the settle interval.
- R3: While a read is in progress, data_avail_n low sets lane_a_en and lane_b_en together in the next cycle; both stay high until the controller returns to idle, and data_avail_n has no effect on the lanes during a write.
- R4: For a write (wr_n low), a write-timing interval of WRTIME_CYC cycles (default 25) runs after the settle interval, followed by a zone write pulse lasting ZONE_CYC cycles (default 25).
- R5: Zone steering: with byte_n low, addr0 = 1 asserts only zone1_we and addr0 = 0 asserts only zone2_we; with byte_n high both zone1_we and zone2_we are asserted.
- R6: byte_mode is high and byte_mode_n is low from the latch point to the return to idle when the latched byte flag is set; otherwise byte_mode is low and byte_mode_n is high.
- R7: After the transfer ends (last rd_init cycle or data arrival, whichever is later, for a read; last zone pulse cycle for a write) a delay of DLY_CYC cycles (default 5) passes, then done_n is low for DONE_CYC cycles (default 5).
- R8: After the completion pulse the controller issues no new pulse while the strobe stays low, and returns to idle in the cycle after the strobe goes high.
- R9: A strobe that is low while mem_avail is low starts nothing; the transfer begins when mem_avail rises, with the same settle timing as an ordinary start.
- R10: Synchronous active-high reset returns the controller to idle from any state with rd_init, zone1_we, zone2_we, lane_a_en, lane_b_en and byte_mode low and done_n and byte_mode_n high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| strb_n | input | 1 | Master strobe, active low |
| wr_n | input | 1 | Low selects write, high selects read |
| byte_n | input | 1 | Low selects a byte transfer |
| addr0 | input | 1 | Lowest address bit, picks the zone for byte writes |
| data_avail_n | input | 1 | Memory read data ready, active low |
| mem_avail | input | 1 | Memory ready to start a new cycle |
| rd_init | output | 1 | Read-initiate pulse to the memory |
| zone1_we | output | 1 | Write enable for zone 1 |
| zone2_we | output | 1 | Write enable for zone 2 |
| lane_a_en | output | 1 | Data lane A enable toward the bus |
| lane_b_en | output | 1 | Data lane B enable toward the bus |
| byte_mode | output | 1 | Latched byte flag, true polarity |
| byte_mode_n | output | 1 | Latched byte flag, complement polarity |
| done_n | output | 1 | Completion pulse to the master, active low |

## Verification
The bench builds the sequencer with its default interval lengths (settle 4, read-initiate 25, write-timing 25, zone pulse 25, delay 5, done 5 cycles), so every pulse can be measured to the exact cycle and a whole transfer fits in well under a hundred cycles. With those values both read orderings are reachable: data arriving inside the read-initiate pulse, and data arriving after it, where the delay stage must wait for the data. All three zone patterns, a strobe held off by a busy memory, a held strobe after completion and a reset in the middle of a zone pulse are driven as directed scenarios.

// File: rtl/core_seq_pkg.sv
package core_seq_pkg;

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_SETTLE,
        SQ_RDINIT,
        SQ_RDWAIT,
        SQ_WRTIME,
        SQ_ZONE,
        SQ_DELAY,
        SQ_DONE,
        SQ_HOLD
    } seq_state_e;

    // Latched master command
    typedef struct packed {
        logic valid;
        logic is_read;
        logic is_byte;
        logic addr0;
    } seq_cmd_t;

    // Sequencer registers
    typedef struct packed {
        seq_state_e state;
        logic       data_seen;
    } seq_regs_t;

    function automatic int imax(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/seq_timer.sv
module seq_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         last
);
    logic [W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt_q <= '0;
        else     cnt_q <= cnt_d;
    end

    // High during the final cycle of a loaded interval
    assign last = (cnt_q == W'(1));
endmodule

// File: rtl/cmd_latch.sv
module cmd_latch
    import core_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     capture,
    input  logic     clear,
    input  logic     wr_n,
    input  logic     byte_n,
    input  logic     addr0,
    output seq_cmd_t cmd
);
    seq_cmd_t cmd_d, cmd_q;

    always_comb begin
        cmd_d = cmd_q;
        if (clear) begin
            cmd_d = '0;
        end else if (capture) begin
            cmd_d.valid   = 1'b1;
            cmd_d.is_read = wr_n;
            cmd_d.is_byte = ~byte_n;
            cmd_d.addr0   = addr0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cmd_q <= '0;
        else     cmd_q <= cmd_d;
    end

    assign cmd = cmd_q;
endmodule

// File: rtl/zone_steer.sv
module zone_steer
    import core_seq_pkg::*;
#(
    parameter int ZONES = 2
) (
    input  seq_cmd_t         cmd,
    input  logic             active,
    output logic [ZONES-1:0] zone_en
);
    // Zone 0 answers to address bit 0 high, zone 1 to address bit 0 low.
    for (genvar z = 0; z < ZONES; z++) begin : g_zone
        localparam logic PICK = (z == 0) ? 1'b1 : 1'b0;
        assign zone_en[z] = active & (~cmd.is_byte | (cmd.addr0 == PICK));
    end
endmodule

// File: rtl/core_cmd_seq.sv
module core_cmd_seq
    import core_seq_pkg::*;
#(
    parameter int SETTLE_CYC = 4,
    parameter int RDINIT_CYC = 25,
    parameter int WRTIME_CYC = 25,
    parameter int ZONE_CYC   = 25,
    parameter int DLY_CYC    = 5,
    parameter int DONE_CYC   = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic strb_n,
    input  logic wr_n,
    input  logic byte_n,
    input  logic addr0,
    input  logic data_avail_n,
    input  logic mem_avail,
    output logic rd_init,
    output logic zone1_we,
    output logic zone2_we,
    output logic lane_a_en,
    output logic lane_b_en,
    output logic byte_mode,
    output logic byte_mode_n,
    output logic done_n
);
    localparam int MAX_CYC = imax(imax(imax(SETTLE_CYC, RDINIT_CYC), imax(WRTIME_CYC, ZONE_CYC)),
                                  imax(DLY_CYC, DONE_CYC));
    localparam int CNT_W   = $clog2(MAX_CYC + 1);

    seq_regs_t        cur_q, cur_d;
    logic             t_load;
    logic [CNT_W-1:0] t_val;
    logic             t_last;
    logic             cap, clr;
    seq_cmd_t         cmd;
    logic [1:0]       zones;

    seq_timer #(.W(CNT_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (t_load),
        .load_val (t_val),
        .last     (t_last)
    );

    cmd_latch u_cmd (
        .clk     (clk),
        .rst     (rst),
        .capture (cap),
        .clear   (clr),
        .wr_n    (wr_n),
        .byte_n  (byte_n),
        .addr0   (addr0),
        .cmd     (cmd)
    );

    zone_steer #(.ZONES(2)) u_zone (
        .cmd     (cmd),
        .active  (cur_q.state == SQ_ZONE),
        .zone_en (zones)
    );

    always_comb begin
        cur_d  = cur_q;
        t_load = 1'b0;
        t_val  = '0;
        cap    = 1'b0;
        clr    = 1'b0;
        unique case (cur_q.state)
            SQ_IDLE: begin
                if (!strb_n && mem_avail) begin
                    cur_d.state = SQ_SETTLE;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(SETTLE_CYC);
                end
            end
            SQ_SETTLE: begin
                if (t_last) begin
                    cap    = 1'b1;
                    t_load = 1'b1;
                    if (wr_n) begin
                        cur_d.state = SQ_RDINIT;
                        t_val       = CNT_W'(RDINIT_CYC);
                    end else begin
                        cur_d.state = SQ_WRTIME;
                        t_val       = CNT_W'(WRTIME_CYC);
                    end
                end
            end
            SQ_RDINIT: begin
                if (!data_avail_n) cur_d.data_seen = 1'b1;
                if (t_last) begin
                    if (cur_q.data_seen || !data_avail_n) begin
                        cur_d.state = SQ_DELAY;
                        t_load      = 1'b1;
                        t_val       = CNT_W'(DLY_CYC);
                    end else begin
                        cur_d.state = SQ_RDWAIT;
                    end
                end
            end
            SQ_RDWAIT: begin
                if (!data_avail_n) begin
                    cur_d.data_seen = 1'b1;
                    cur_d.state     = SQ_DELAY;
                    t_load          = 1'b1;
                    t_val           = CNT_W'(DLY_CYC);
                end
            end
            SQ_WRTIME: begin
                if (t_last) begin
                    cur_d.state = SQ_ZONE;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(ZONE_CYC);
                end
            end
            SQ_ZONE: begin
                if (t_last) begin
                    cur_d.state = SQ_DELAY;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(DLY_CYC);
                end
            end
            SQ_DELAY: begin
                if (t_last) begin
                    cur_d.state = SQ_DONE;
                    t_load      = 1'b1;
                    t_val       = CNT_W'(DONE_CYC);
                end
            end
            SQ_DONE: begin
                if (t_last) cur_d.state = SQ_HOLD;
            end
            SQ_HOLD: begin
                if (strb_n) begin
                    cur_d.state     = SQ_IDLE;
                    cur_d.data_seen = 1'b0;
                    clr             = 1'b1;
                end
            end
            default: begin
                cur_d = '0;
                clr   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) cur_q <= '{state: SQ_IDLE, data_seen: 1'b0};
        else     cur_q <= cur_d;
    end

    assign rd_init     = (cur_q.state == SQ_RDINIT);
    assign zone1_we    = zones[0];
    assign zone2_we    = zones[1];
    assign lane_a_en   = cur_q.data_seen;
    assign lane_b_en   = cur_q.data_seen;
    assign byte_mode   = cmd.valid & cmd.is_byte;
    assign byte_mode_n = ~(cmd.valid & cmd.is_byte);
    assign done_n      = (cur_q.state != SQ_DONE);
endmodule

// File: rtl/core_cmd_seq_chk.sv
module core_cmd_seq_chk (
    input logic clk,
    input logic rst,
    input logic rd_init,
    input logic zone1_we,
    input logic zone2_we,
    input logic lane_a_en,
    input logic byte_mode,
    input logic done_n
);
    // R2 R4
    rd_zone_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rd_init && (zone1_we || zone2_we)));

    // R5
    both_zone_word_chk: assert property (@(posedge clk) disable iff (rst)
        (zone1_we && zone2_we) |-> !byte_mode);

    // R5
    single_zone_byte_chk: assert property (@(posedge clk) disable iff (rst)
        (zone1_we != zone2_we) |-> byte_mode);

    // R3
    lane_not_write_chk: assert property (@(posedge clk) disable iff (rst)
        lane_a_en |-> !(zone1_we || zone2_we));

    // R7
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !done_n |-> !(rd_init || zone1_we || zone2_we));

    // R7
    done_hold_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(done_n) |=> !done_n);

    // R10
    reset_clear_chk: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (done_n && !rd_init && !lane_a_en && !zone1_we && !zone2_we));
endmodule

bind core_cmd_seq core_cmd_seq_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .rd_init   (rd_init),
    .zone1_we  (zone1_we),
    .zone2_we  (zone2_we),
    .lane_a_en (lane_a_en),
    .byte_mode (byte_mode),
    .done_n    (done_n)
);

// File: tb/sim_core_cmd_seq.sv
module sim_core_cmd_seq;
    localparam int SET_C = 4;
    localparam int RD_C  = 25;
    localparam int WT_C  = 25;
    localparam int ZN_C  = 25;
    localparam int DL_C  = 5;
    localparam int DN_C  = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic strb_n = 1'b1, wr_n = 1'b1, byte_n = 1'b1, addr0 = 1'b0;
    logic data_avail_n = 1'b1, mem_avail = 1'b1;
    logic rd_init, zone1_we, zone2_we, lane_a_en, lane_b_en, byte_mode, byte_mode_n, done_n;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;

    core_cmd_seq #(
        .SETTLE_CYC(SET_C), .RDINIT_CYC(RD_C), .WRTIME_CYC(WT_C),
        .ZONE_CYC(ZN_C), .DLY_CYC(DL_C), .DONE_CYC(DN_C)
    ) u0 (
        .clk(clk), .rst(rst), .strb_n(strb_n), .wr_n(wr_n), .byte_n(byte_n),
        .addr0(addr0), .data_avail_n(data_avail_n), .mem_avail(mem_avail),
        .rd_init(rd_init), .zone1_we(zone1_we), .zone2_we(zone2_we),
        .lane_a_en(lane_a_en), .lane_b_en(lane_b_en), .byte_mode(byte_mode),
        .byte_mode_n(byte_mode_n), .done_n(done_n)
    );

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            errors++;
            $display("FAIL watchdog expired act=%0d exp<=20000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic idle_outputs(input string req);
        chk({req, " rd_init"}, rd_init, 0);
        chk({req, " zones"}, {zone1_we, zone2_we}, 0);
        chk({req, " lanes"}, {lane_a_en, lane_b_en}, 0);
        chk({req, " byte_mode"}, {byte_mode, byte_mode_n}, 1);
        chk({req, " done_n"}, done_n, 1);
    endtask

    // Hold strobe after done, then release and check return to idle
    task automatic finish_hold(input bit is_byte);
        int bad = 0;
        for (int i = 0; i < 10; i++) begin
            tick();
            if (rd_init || zone1_we || zone2_we || !done_n) bad++;
        end
        chk("R8 no activity while strobe held", bad, 0);
        chk("R6 byte_mode held until idle", byte_mode, is_byte);
        strb_n = 1'b1; data_avail_n = 1'b1; wr_n = 1'b1; byte_n = 1'b1; addr0 = 1'b0;
        tick();
        idle_outputs("R8 idle after release");
        repeat (2) tick();
    endtask

    task automatic run_read(input bit is_byte, input bit a0, input int data_delay, input int gate);
        int t = 0, rd_rise = -1, rd_last = -1, ln_rise = -1, dn_fall = -1, dn_last = -1, dtick = -1;
        int mism = 0, zseen = 0, bm = -1, bmn = -1, early_rd = 0;
        wr_n = 1'b1; byte_n = ~is_byte; addr0 = a0; data_avail_n = 1'b1;
        if (gate > 0) begin
            mem_avail = 1'b0;
            strb_n = 1'b0;
            for (int i = 0; i < gate; i++) begin
                tick();
                if (rd_init || !done_n) early_rd++;
            end
            chk("R9 nothing starts while memory busy", early_rd, 0);
            mem_avail = 1'b1;
        end else begin
            strb_n = 1'b0;
        end
        while (t < 200 && !(dn_last >= 0 && done_n)) begin
            tick();
            t++;
            if (rd_init) begin
                if (rd_rise < 0) begin
                    rd_rise = t;
                    bm = byte_mode;
                    bmn = byte_mode_n;
                end
                rd_last = t;
            end
            if (lane_a_en && ln_rise < 0) ln_rise = t;
            if (lane_a_en != lane_b_en) mism++;
            if (zone1_we || zone2_we) zseen++;
            if (!done_n) begin
                if (dn_fall < 0) dn_fall = t;
                dn_last = t;
            end
            if (rd_rise >= 0 && t == rd_rise + 1) begin
                // R1: disturb the command after it was latched
                wr_n = 1'b0; byte_n = is_byte; addr0 = ~a0;
            end
            if (rd_rise >= 0 && t == rd_rise + data_delay) begin
                data_avail_n = 1'b0;
                dtick = t;
            end
        end
        chk(gate > 0 ? "R9 read starts after mem_avail rises" : "R2 rd_init start after settle",
            rd_rise, SET_C + 1);
        chk("R2 rd_init width", rd_last - rd_rise + 1, RD_C);
        chk("R3 lanes rise after data", ln_rise, dtick + 1);
        chk("R3 lanes equal", mism, 0);
        chk("R1 read not turned into write", zseen, 0);
        chk("R6 byte_mode at read", bm, is_byte);
        chk("R6 byte_mode_n at read", bmn, !is_byte);
        chk("R7 done fall after delay", dn_fall, ((rd_last > dtick) ? rd_last : dtick) + DL_C + 1);
        chk("R7 done width", dn_last - dn_fall + 1, DN_C);
        chk("R3 lanes held to hold state", lane_a_en & lane_b_en, 1);
        finish_hold(is_byte);
    endtask

    task automatic run_write(input bit is_byte, input bit a0, input bit spurious);
        int t = 0, z_rise = -1, z_last = -1, dn_fall = -1, dn_last = -1;
        int z1 = -1, z2 = -1, lanes = 0, rds = 0, bm = -1;
        wr_n = 1'b0; byte_n = ~is_byte; addr0 = a0;
        data_avail_n = spurious ? 1'b0 : 1'b1;
        strb_n = 1'b0;
        while (t < 200 && !(dn_last >= 0 && done_n)) begin
            tick();
            t++;
            if (zone1_we || zone2_we) begin
                if (z_rise < 0) begin
                    z_rise = t;
                    z1 = zone1_we;
                    z2 = zone2_we;
                    bm = byte_mode;
                end
                z_last = t;
            end
            if (lane_a_en || lane_b_en) lanes++;
            if (rd_init) rds++;
            if (!done_n) begin
                if (dn_fall < 0) dn_fall = t;
                dn_last = t;
            end
            if (t == SET_C + 2) begin
                // R1: disturb the command after it was latched
                wr_n = 1'b1; byte_n = is_byte; addr0 = ~a0;
            end
        end
        chk("R4 zone pulse after write timing", z_rise, SET_C + WT_C + 1);
        chk("R4 zone pulse width", z_last - z_rise + 1, ZN_C);
        chk("R5 zone1_we", z1, is_byte ? a0 : 1);
        chk("R5 zone2_we", z2, is_byte ? !a0 : 1);
        chk("R6 byte_mode at write", bm, is_byte);
        chk("R3 no lanes in write", lanes, 0);
        chk("R1 write not turned into read", rds, 0);
        chk("R7 done fall after zone", dn_fall, z_last + DL_C + 1);
        chk("R7 done width", dn_last - dn_fall + 1, DN_C);
        finish_hold(is_byte);
    endtask

    task automatic reset_state();
        repeat (3) tick();
        idle_outputs("R10 reset state");
        rst = 1'b0;
        repeat (2) tick();
        idle_outputs("R10 idle after reset");
    endtask

    task automatic reset_mid_cycle();
        wr_n = 1'b0; byte_n = 1'b1; addr0 = 1'b0; strb_n = 1'b0;
        repeat (SET_C + WT_C + 5) tick();
        chk("R10 zone active before reset", zone1_we & zone2_we, 1);
        rst = 1'b1;
        tick();
        idle_outputs("R10 reset mid cycle");
        strb_n = 1'b1; wr_n = 1'b1;
        tick();
        rst = 1'b0;
        repeat (3) tick();
        idle_outputs("R10 idle after mid reset");
    endtask

    initial begin
        reset_state();
        run_read(1'b0, 1'b0, 10, 0);
        run_read(1'b1, 1'b1, 32, 0);
        run_write(1'b0, 1'b1, 1'b0);
        run_write(1'b1, 1'b1, 1'b0);
        run_write(1'b1, 1'b0, 1'b1);
        run_read(1'b1, 1'b0, 24, 30);
        reset_mid_cycle();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule